// File: doc/BRIEF.md
# Whole-Event Admission Channel Buffer

This block is the per-channel holding buffer between a pipeline that emits accepted events and a board-level collector that gathers events from several channels. The storage holds 16-bit words. Each event is one fixed-size header followed by a variable run of waveform samples. The producer announces each event with a start strobe that carries the event's total length in words. The block then decides, on that same cycle, whether the complete event fits in the space that is free.

An event that fits is written word by word. An event that does not fit, or whose announced length is shorter than the header, is discarded as a unit. No word of a discarded event enters the storage, and a saturating loss counter records the event. The read side only ever exposes events whose last word has already been written. It tags the opening and closing word of each event, so the collector can move exactly one event at a time.

A fill-level output and a throttle request with hysteresis let the trigger logic pause new accepts before the buffer starts to lose events.

Top module: `evt_admit_fifo`

## Requirements
- R1: After reset the block is empty: `out_valid`=0, `fill_level`=0, `drop_count`=0 and `throttle_req`=0.
- R2: An event whose length is at least `HDR_WORDS` and at most the free space (`DEPTH` minus `fill_level`) on its start cycle is admitted. This holds even when it fills the buffer exactly. All its words are stored and read out in arrival order.
- R3: An event whose length exceeds the free space on its start cycle is discarded whole: none of its words are stored, and `drop_count` rises by one.
- R4: An event announced with a length below `HDR_WORDS`, including zero, is discarded and counted in the same way as in R3.
- R5: The read side never presents a word of an event before that event's last word has been written. Once the first word of an event is offered, every later word of that event is available on the cycle after the previous one is taken.
- R6: `out_first`=1 on the first word of each event, and only there. `out_last`=1 on the last word of each event, and only there. For a one-word event both flags are 1.
- R7: `drop_count` saturates at 2^`CNT_W`-1 and then holds that value.
- R8: `throttle_req` becomes 1 on the cycle after `fill_level` > `thr_high`. It becomes 0 on the cycle after `fill_level` < `thr_low`. Otherwise it keeps its value.
- R9: `fill_level` equals the words written minus the words read, counting words of an event that is still being written. It never exceeds `DEPTH`.
- R10: Words offered with `in_valid`=1 that do not belong to an admitted event are ignored. This covers words after a discarded start and words with no start. They leave `fill_level` and the read side unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_sof | input | 1 | Marks the first word of an event, qualified by in_valid |
| in_len | input | LEN_W | Total event length in words, sampled with in_sof |
| in_data | input | DATA_W | Input word |
| out_ready | input | 1 | Collector takes the presented word |
| out_valid | output | 1 | A word of a fully stored event is presented |
| out_data | output | DATA_W | Presented word |
| out_first | output | 1 | Presented word opens an event |
| out_last | output | 1 | Presented word closes an event |
| fill_level | output | LEN_W | Occupied words |
| thr_high | input | LEN_W | Level above which throttle is requested |
| thr_low | input | LEN_W | Level below which throttle is released |
| throttle_req | output | 1 | Throttle request to the trigger |
| drop_count | output | CNT_W | Saturating count of discarded events |

## Verification
The hardest cases to reach are at the admission boundary. One is an event that needs exactly the free space. Another needs one word more. A third arrives while the collector is freeing space in the same cycle. The bench first sweeps every length from zero to beyond the depth into an empty buffer. It then pre-fills the buffer to many levels and offers an event one word too large, followed by one that fits exactly. Finally it runs continuous traffic with a stuttering reader, so that admission decisions coincide with reads. A cycle-accurate model checks every output on every cycle.

// File: rtl/evt_fifo_pkg.sv
package evt_fifo_pkg;

  typedef enum logic {
    WR_IDLE = 1'b0,
    WR_BODY = 1'b1
  } wr_state_e;

  typedef struct packed {
    logic first;
    logic last;
  } evt_mark_t;

endpackage

// File: rtl/evt_admit_ctrl.sv
module evt_admit_ctrl
  import evt_fifo_pkg::*;
#(
  parameter int HDR_WORDS = 28,
  parameter int LEN_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [LEN_W-1:0] in_len,
  input  logic [LEN_W-1:0] free_cnt,
  output logic             wr_en,
  output evt_mark_t        wr_mark,
  output logic             commit,
  output logic             drop,
  output logic             busy
);

  localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(HDR_WORDS);
  localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

  wr_state_e        state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             len_ok;
  logic             rem_en;

  assign len_ok = (in_len >= HDR_LEN) && (in_len <= free_cnt);
  assign rem_en = in_valid;
  assign busy   = (state_q == WR_BODY);

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    wr_en   = 1'b0;
    wr_mark = '0;
    commit  = 1'b0;
    drop    = 1'b0;
    unique case (state_q)
      WR_IDLE: begin
        if (in_valid && in_sof) begin
          if (len_ok) begin
            wr_en         = 1'b1;
            wr_mark.first = 1'b1;
            if (in_len == ONE) begin
              wr_mark.last = 1'b1;
              commit       = 1'b1;
            end else begin
              state_d = WR_BODY;
              rem_d   = in_len - ONE;
            end
          end else begin
            drop = 1'b1;
          end
        end
      end
      WR_BODY: begin
        if (in_valid) begin
          wr_en = 1'b1;
          rem_d = rem_q - ONE;
          if (rem_q == ONE) begin
            wr_mark.last = 1'b1;
            commit       = 1'b1;
            state_d      = WR_IDLE;
          end
        end
      end
      default: state_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      rem_q   <= '0;
    end else if (rem_en) begin
      state_q <= state_d;
      rem_q   <= rem_d;
    end
  end

endmodule

// File: rtl/evt_word_store.sv
module evt_word_store
  import evt_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048,
  parameter int PTR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  evt_mark_t         wr_mark,
  input  logic              commit,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output evt_mark_t         rd_mark,
  output logic              rd_avail,
  output logic [PTR_W-1:0]  level
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int WORD_W = DATA_W + 2;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [PTR_W-1:0]  cmt_ptr_q, cmt_ptr_d;
  logic              ptr_en;
  logic [WORD_W-1:0] rd_word;

  assign ptr_en = wr_en | commit | rd_pop;

  always_comb begin
    wr_ptr_d  = wr_ptr_q;
    rd_ptr_d  = rd_ptr_q;
    cmt_ptr_d = cmt_ptr_q;
    if (wr_en)  wr_ptr_d  = wr_ptr_q + PTR_W'(1);
    if (commit) cmt_ptr_d = wr_ptr_q + PTR_W'(1);
    if (rd_pop) rd_ptr_d  = rd_ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      cmt_ptr_q <= '0;
    end else if (ptr_en) begin
      wr_ptr_q  <= wr_ptr_d;
      rd_ptr_q  <= rd_ptr_d;
      cmt_ptr_q <= cmt_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q[ADDR_W-1:0]] <= {wr_mark, wr_data};
  end

  assign rd_word  = mem[rd_ptr_q[ADDR_W-1:0]];
  assign rd_data  = rd_word[DATA_W-1:0];
  assign rd_mark  = rd_word[WORD_W-1:DATA_W];
  assign rd_avail = (cmt_ptr_q != rd_ptr_q);
  assign level    = wr_ptr_q - rd_ptr_q;

endmodule

// File: rtl/evt_hyst_throttle.sv
module evt_hyst_throttle #(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] hi_thr,
  input  logic [LVL_W-1:0] lo_thr,
  output logic             req
);

  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (level > hi_thr)      req_d = 1'b1;
    else if (level < lo_thr) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;

endmodule

// File: rtl/evt_sat_counter.sv
module evt_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = inc && (cnt_q != CNT_MAX);
  assign cnt_d  = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/evt_admit_fifo.sv
module evt_admit_fifo
  import evt_fifo_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 2048,
  parameter int HDR_WORDS = 28,
  parameter int CNT_W     = 16,
  localparam int LEN_W    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last,
  output logic [LEN_W-1:0]  fill_level,
  input  logic [LEN_W-1:0]  thr_high,
  input  logic [LEN_W-1:0]  thr_low,
  output logic              throttle_req,
  output logic [CNT_W-1:0]  drop_count
);

  logic             wr_en;
  evt_mark_t        wr_mark;
  logic             commit;
  logic             drop;
  logic             wr_busy;
  logic             rd_pop;
  logic             rd_avail;
  evt_mark_t        rd_mark;
  logic [LEN_W-1:0] level;
  logic [LEN_W-1:0] free_cnt;

  assign free_cnt = LEN_W'(DEPTH) - level;
  assign rd_pop   = rd_avail && out_ready;

  evt_admit_ctrl #(
    .HDR_WORDS(HDR_WORDS),
    .LEN_W    (LEN_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_sof  (in_sof),
    .in_len  (in_len),
    .free_cnt(free_cnt),
    .wr_en   (wr_en),
    .wr_mark (wr_mark),
    .commit  (commit),
    .drop    (drop),
    .busy    (wr_busy)
  );

  evt_word_store #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .PTR_W (LEN_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (in_data),
    .wr_mark (wr_mark),
    .commit  (commit),
    .rd_pop  (rd_pop),
    .rd_data (out_data),
    .rd_mark (rd_mark),
    .rd_avail(rd_avail),
    .level   (level)
  );

  evt_hyst_throttle #(
    .LVL_W(LEN_W)
  ) u_thr (
    .clk   (clk),
    .rst_n (rst_n),
    .level (level),
    .hi_thr(thr_high),
    .lo_thr(thr_low),
    .req   (throttle_req)
  );

  evt_sat_counter #(
    .CNT_W(CNT_W)
  ) u_drop (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (drop),
    .count(drop_count)
  );

  assign out_valid  = rd_avail;
  assign out_first  = rd_mark.first;
  assign out_last   = rd_mark.last;
  assign fill_level = level;

endmodule

// File: rtl/evt_admit_fifo_chk.sv
module evt_admit_fifo_chk #(
  parameter int DEPTH = 2048,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic [LEN_W-1:0] in_len,
  input logic             out_ready,
  input logic             out_valid,
  input logic             out_last,
  input logic [LEN_W-1:0] fill_level,
  input logic [LEN_W-1:0] thr_high,
  input logic [LEN_W-1:0] thr_low,
  input logic             throttle_req,
  input logic [CNT_W-1:0] drop_count,
  input logic             wr_busy
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [LEN_W-1:0] DEP     = LEN_W'(DEPTH);

  // R9: occupancy bounded by depth
  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= DEP);

  // R3: event larger than free space is counted as a loss
  p_oversize_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !wr_busy && (in_len > (DEP - fill_level)) && (drop_count != CNT_MAX))
    |=> (drop_count == $past(drop_count) + CNT_W'(1)));

  // R7: saturated counter holds
  p_drop_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == CNT_MAX) |=> (drop_count == CNT_MAX));

  // R3: counter moves by at most one per cycle, never down
  p_drop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + CNT_W'(1))));

  // R5: rest of an event is already stored once its words are being taken
  p_event_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid);

  // R8: hysteresis set and release
  p_thr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level > thr_high) |=> throttle_req);

  p_thr_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill_level < thr_low) && !(fill_level > thr_high)) |=> !throttle_req);

  p_thr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fill_level < thr_low) && !(fill_level > thr_high)) |=> (throttle_req == $past(throttle_req)));

  // R10: no new start while an admitted event is still arriving
  p_no_nested_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !(in_valid && in_sof));

endmodule

bind evt_admit_fifo evt_admit_fifo_chk #(
  .DEPTH(DEPTH),
  .LEN_W(LEN_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_sof      (in_sof),
  .in_len      (in_len),
  .out_ready   (out_ready),
  .out_valid   (out_valid),
  .out_last    (out_last),
  .fill_level  (fill_level),
  .thr_high    (thr_high),
  .thr_low     (thr_low),
  .throttle_req(throttle_req),
  .drop_count  (drop_count),
  .wr_busy     (wr_busy)
);

// File: tb/evt_admit_fifo_test.sv
module evt_admit_fifo_test;

  localparam int DW    = 16;
  localparam int DEP   = 32;
  localparam int HDR   = 4;
  localparam int CW    = 3;
  localparam int LW    = 6;
  localparam int CMAX  = 7;
  localparam int THI   = 20;
  localparam int TLO   = 10;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_sof;
  logic [LW-1:0] in_len;
  logic [DW-1:0] in_data;
  logic          out_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_first;
  logic          out_last;
  logic [LW-1:0] fill_level;
  logic [LW-1:0] thr_high;
  logic [LW-1:0] thr_low;
  logic          throttle_req;
  logic [CW-1:0] drop_count;

  int n_checks;
  int n_fails;
  int cycles;
  bit done;

  // model state: each entry {first, last, data}
  logic [DW+1:0] cq[$];
  logic [DW+1:0] pend[$];
  bit            m_active;
  int            m_rem;
  int            m_drops;
  bit            m_thr;

  evt_admit_fifo #(
    .DATA_W   (DW),
    .DEPTH    (DEP),
    .HDR_WORDS(HDR),
    .CNT_W    (CW)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .in_len      (in_len),
    .in_data     (in_data),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_first   (out_first),
    .out_last    (out_last),
    .fill_level  (fill_level),
    .thr_high    (thr_high),
    .thr_low     (thr_low),
    .throttle_req(throttle_req),
    .drop_count  (drop_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic compare_all();
    int lvl;
    lvl = cq.size() + pend.size();
    chk(out_valid == (cq.size() != 0), "R5 out_valid", int'(out_valid), int'(cq.size() != 0));
    chk(int'(fill_level) == lvl, "R9 fill_level", int'(fill_level), lvl);
    chk(int'(drop_count) == m_drops, "R3 R7 drop_count", int'(drop_count), m_drops);
    chk(throttle_req == m_thr, "R8 throttle_req", int'(throttle_req), int'(m_thr));
    if (cq.size() != 0 && out_valid) begin
      chk(out_data == cq[0][DW-1:0], "R2 out_data", int'(out_data), int'(cq[0][DW-1:0]));
      chk(out_first == cq[0][DW+1], "R6 out_first", int'(out_first), int'(cq[0][DW+1]));
      chk(out_last == cq[0][DW], "R6 out_last", int'(out_last), int'(cq[0][DW]));
    end
  endtask

  // one clock cycle: drive at negedge, model, wait edge, compare at next negedge
  task automatic cyc(input bit v, input bit s, input int len, input logic [DW-1:0] d, input bit rdy);
    int  lvl;
    bit  pop;
    in_valid  = v;
    in_sof    = s;
    in_len    = LW'(len);
    in_data   = d;
    out_ready = rdy;
    lvl = cq.size() + pend.size();
    pop = rdy && (cq.size() != 0);
    if (lvl > THI)      m_thr = 1'b1;
    else if (lvl < TLO) m_thr = 1'b0;
    if (pop) void'(cq.pop_front());
    if (v && !m_active && s) begin
      if (len >= HDR && len <= DEP - lvl) begin
        pend.push_back({1'b1, (len == 1), d});
        if (len == 1) begin
          while (pend.size() != 0) cq.push_back(pend.pop_front());
        end else begin
          m_active = 1'b1;
          m_rem    = len - 1;
        end
      end else if (m_drops < CMAX) begin
        m_drops++;
      end
    end else if (v && m_active) begin
      pend.push_back({1'b0, (m_rem == 1), d});
      m_rem--;
      if (m_rem == 0) begin
        m_active = 1'b0;
        while (pend.size() != 0) cq.push_back(pend.pop_front());
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic send_event(input int id, input int len, input int rdy_mode);
    int n;
    n = (len < 1) ? 1 : len;
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, (i == 0), len, DW'((id << 8) | (i & 8'hff)),
          (rdy_mode == 0) ? 1'b0 : (rdy_mode == 1) ? 1'b1 : ((i % 3) != 0));
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 4 * DEP && (cq.size() != 0 || pend.size() != 0); k++)
      cyc(1'b0, 1'b0, 0, '0, 1'b1);
  endtask

  initial begin
    for (int w = 0; w < 150000; w++) begin
      @(posedge clk);
      cycles++;
    end
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    finish_run();
  end

  initial begin
    int lv;
    int dbefore;
    done      = 1'b0;
    n_checks  = 0;
    n_fails   = 0;
    m_active  = 1'b0;
    m_rem     = 0;
    m_drops   = 0;
    m_thr     = 1'b0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sof    = 1'b0;
    in_len    = '0;
    in_data   = '0;
    out_ready = 1'b0;
    thr_high  = LW'(THI);
    thr_low   = LW'(TLO);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(fill_level == '0, "R1 fill_level", int'(fill_level), 0);
    chk(drop_count == '0, "R1 drop_count", int'(drop_count), 0);
    chk(throttle_req == 1'b0, "R1 throttle_req", int'(throttle_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep every length into an empty buffer (R2, R4, R5, R6)
    for (int len = 0; len <= DEP + 2; len++) begin
      dbefore = m_drops;
      send_event(len, len, 0);
      if (len < HDR) begin
        chk(int'(fill_level) == 0, "R4 short event stored nothing", int'(fill_level), 0);
        chk(int'(drop_count) == dbefore + 1, "R4 short event counted", int'(drop_count), dbefore + 1);
      end
      drain();
    end

    // boundary around the free space at many fill levels (R2, R3, R7)
    for (int p = HDR; p <= DEP - HDR; p += 3) begin
      send_event(8'h40 + p, p, 0);
      lv = int'(fill_level);
      send_event(8'h80 + p, DEP - p + 1, 0);
      chk(int'(fill_level) == lv, "R3 oversize stored nothing", int'(fill_level), lv);
      send_event(8'hC0 + p, DEP - p, 0);
      chk(int'(fill_level) == DEP, "R2 exact fit fills buffer", int'(fill_level), DEP);
      drain();
    end
    chk(int'(drop_count) == CMAX, "R7 saturated", int'(drop_count), CMAX);

    // continuous traffic with a stuttering reader (R2, R5, R6, R8)
    for (int e = 0; e < 40; e++) send_event(e, HDR + (e * 5) % 13, 2);
    drain();

    // stray words with no start are ignored (R10)
    for (int s = 0; s < 5; s++) cyc(1'b1, 1'b0, 9, DW'(16'hBEEF), 1'b0);
    chk(int'(fill_level) == 0, "R10 stray words", int'(fill_level), 0);
    chk(out_valid == 1'b0, "R10 no output", int'(out_valid), 0);

    finish_run();
  end

endmodule